// File: doc/BRIEF.md
# Configurable Logic Cell Register

This block is one programmable cell of a sum-of-products logic fabric. Four sum terms (A, B, C, D) arrive from the fabric's AND/OR plane. Static configuration inputs then decide what each term does. A term can be register data, a second register input, a clock source, a local preset or reset, a plain combinational path, or the output enable of a neighbouring I/O cell. The cell holds a single storage bit. That bit can behave as a D, T or JK flip-flop. A fabric-wide type control can turn a D-configured cell into T or JK behaviour at run time, so a loadable counter can load in D mode and count in T mode.

All state is held in the fabric clock domain `clk`. The selected register clock is sampled every fabric cycle, and a rising transition of it (after polarity inversion) produces an update event. The clock can come from the global clock line, from sum C or from sum D. Preset, reset and the synchronous power-on reset `rst` override any update. Each data output picks either the stored bit or one of the sums A, B, C through its own selector.

Top module: `lcc_cell`

## Requirements
- R1: While `rst` is high, the stored bit is cleared to 0 at each `clk` edge, and this wins over every other control.
- R2: In D behaviour, an update event loads the stored bit with sum A.
- R3: In T behaviour (`cfg_kind`=1), an update event inverts the stored bit when sum A is 1 and leaves it unchanged when sum A is 0.
- R4: In JK behaviour (`cfg_kind`=2, J = sum A, K = sum B), an update event acts on J,K as follows: 1,1 inverts the bit, 0,0 keeps it, 1,0 sets it and 0,1 clears it.
- R5: A cell with `cfg_kind` 0 (or 3) behaves as D while `g_regtype` is 0. While `g_regtype` is 1 it behaves as T if `cfg_alt_jk` is 0 and as JK if `cfg_alt_jk` is 1.
- R6: `cfg_clk_src` selects the clock: 1 selects sum C, 2 selects sum D, and 0 or 3 selects `g_clk`. An update event is a 0-to-1 change of the effective clock level seen between two consecutive `clk` edges, and the bit takes its new value at the second of those edges. Without an event, and with no preset or reset, the bit does not change.
- R7: The effective clock level is the selected source XOR `cfg_clk_inv`. For the global source only, it is additionally XORed with `g_clk_neg`. One inversion therefore makes falling edges the active edges, and two inversions restore rising edges.
- R8: Reset is active when `g_reset` is high or when `cfg_c_reset` and sum C are both high. Preset is active when `g_preset` is high or when `cfg_b_preset` and sum B are both high. At a `clk` edge, an active reset clears the bit. Otherwise an active preset sets it. Both take priority over an update event.
- R9: Each output `data_out[i]` is combinational and driven by the 2-bit field `cfg_out_sel[2i+1:2i]`: 0 selects the stored bit, 1 selects sum A, 2 selects sum B and 3 selects sum C.
- R10: `oe` equals sum D unless `cfg_clk_src` is 2, in which case `oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| g_clk | input | 1 | Global clock line, sampled as a level |
| g_clk_neg | input | 1 | Global clock polarity inversion |
| g_preset | input | 1 | Global preset |
| g_reset | input | 1 | Global reset |
| g_regtype | input | 1 | Global dynamic register-type control |
| sum_a | input | 1 | Sum term A |
| sum_b | input | 1 | Sum term B |
| sum_c | input | 1 | Sum term C |
| sum_d | input | 1 | Sum term D |
| cfg_kind | input | 2 | Static register kind: 0 D, 1 T, 2 JK, 3 D |
| cfg_alt_jk | input | 1 | Target of dynamic switch: 0 T, 1 JK |
| cfg_clk_src | input | 2 | Clock source: 0 global, 1 sum C, 2 sum D, 3 global |
| cfg_clk_inv | input | 1 | Per-cell clock inversion |
| cfg_b_preset | input | 1 | Sum B acts as local preset |
| cfg_c_reset | input | 1 | Sum C acts as local reset |
| cfg_out_sel | input | 2*NUM_OUT | Per-output source selector fields |
| data_out | output | NUM_OUT | Cell data outputs |
| oe | output | 1 | Output enable for the paired I/O cell |

## Verification
The assertions take the configuration inputs as constant between resets. A change in source or polarity changes the sampled clock level, and that change can itself be a legitimate event. To stay within this assumption, the bench pulses `rst` after every reconfiguration, which re-aligns the sampled level. The assertions also assume each clock source holds every level for at least one `clk` cycle. The stimulus therefore drives all sums and clock lines only at falling `clk` edges and keeps each level for a full cycle or more. Sum C is never configured as clock and local reset at the same time.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  localparam int OSEL_W = 2;

  typedef enum logic [1:0] {
    KIND_D  = 2'd0,
    KIND_T  = 2'd1,
    KIND_JK = 2'd2,
    KIND_D2 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CSRC_GLOBAL  = 2'd0,
    CSRC_SUMC    = 2'd1,
    CSRC_SUMD    = 2'd2,
    CSRC_GLOBAL2 = 2'd3
  } csrc_e;

  typedef enum logic [OSEL_W-1:0] {
    OSEL_Q = 2'd0,
    OSEL_A = 2'd1,
    OSEL_B = 2'd2,
    OSEL_C = 2'd3
  } osel_e;

  // Fold the dynamic type control into one effective kind.
  function automatic kind_e resolve_kind(input logic [1:0] cfg, input logic dyn,
                                         input logic alt_jk);
    kind_e k;
    k = kind_e'(cfg);
    if (k == KIND_D2) k = KIND_D;
    if (k == KIND_D && dyn) k = alt_jk ? KIND_JK : KIND_T;
    return k;
  endfunction

endpackage

// File: rtl/lcc_clk_edge.sv
module lcc_clk_edge
  import lcc_pkg::*;
(
  input  logic       clk,
  input  logic       g_clk,
  input  logic       g_clk_neg,
  input  logic       sum_c,
  input  logic       sum_d,
  input  logic [1:0] src,
  input  logic       cell_inv,
  output logic       ev
);

  logic raw_lvl;
  logic eff_lvl;
  logic prev_lvl;

  always_comb begin
    case (csrc_e'(src))
      CSRC_SUMC: raw_lvl = sum_c;
      CSRC_SUMD: raw_lvl = sum_d;
      default:   raw_lvl = g_clk ^ g_clk_neg;
    endcase
    eff_lvl = raw_lvl ^ cell_inv;
  end

  always_ff @(posedge clk) begin
    prev_lvl <= eff_lvl;
  end

  assign ev = eff_lvl & ~prev_lvl;

endmodule

// File: rtl/lcc_next_state.sv
module lcc_next_state
  import lcc_pkg::*;
(
  input  logic  q,
  input  logic  in_a,
  input  logic  in_b,
  input  kind_e kind,
  output logic  q_nxt
);

  always_comb begin
    case (kind)
      KIND_T:  q_nxt = q ^ in_a;
      KIND_JK: begin
        case ({in_a, in_b})
          2'b11:   q_nxt = ~q;
          2'b10:   q_nxt = 1'b1;
          2'b01:   q_nxt = 1'b0;
          default: q_nxt = q;
        endcase
      end
      default: q_nxt = in_a;
    endcase
  end

endmodule

// File: rtl/lcc_out_mux.sv
module lcc_out_mux
  import lcc_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                      q,
  input  logic                      in_a,
  input  logic                      in_b,
  input  logic                      in_c,
  input  logic [NUM_OUT*OSEL_W-1:0] sel,
  output logic [NUM_OUT-1:0]        y
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_comb begin
      case (osel_e'(sel[i*OSEL_W +: OSEL_W]))
        OSEL_A:  y[i] = in_a;
        OSEL_B:  y[i] = in_b;
        OSEL_C:  y[i] = in_c;
        default: y[i] = q;
      endcase
    end
  end

endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
  import lcc_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      g_clk,
  input  logic                      g_clk_neg,
  input  logic                      g_preset,
  input  logic                      g_reset,
  input  logic                      g_regtype,
  input  logic                      sum_a,
  input  logic                      sum_b,
  input  logic                      sum_c,
  input  logic                      sum_d,
  input  logic [1:0]                cfg_kind,
  input  logic                      cfg_alt_jk,
  input  logic [1:0]                cfg_clk_src,
  input  logic                      cfg_clk_inv,
  input  logic                      cfg_b_preset,
  input  logic                      cfg_c_reset,
  input  logic [NUM_OUT*OSEL_W-1:0] cfg_out_sel,
  output logic [NUM_OUT-1:0]        data_out,
  output logic                      oe
);

  logic  q_r;
  logic  q_nxt;
  logic  clk_ev;
  logic  reset_any;
  logic  preset_any;
  kind_e kind_eff;

  assign kind_eff   = resolve_kind(cfg_kind, g_regtype, cfg_alt_jk);
  assign reset_any  = g_reset  | (cfg_c_reset  & sum_c);
  assign preset_any = g_preset | (cfg_b_preset & sum_b);

  lcc_clk_edge u_edge (
    .clk       (clk),
    .g_clk     (g_clk),
    .g_clk_neg (g_clk_neg),
    .sum_c     (sum_c),
    .sum_d     (sum_d),
    .src       (cfg_clk_src),
    .cell_inv  (cfg_clk_inv),
    .ev        (clk_ev)
  );

  lcc_next_state u_ns (
    .q     (q_r),
    .in_a  (sum_a),
    .in_b  (sum_b),
    .kind  (kind_eff),
    .q_nxt (q_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)             q_r <= 1'b0;
    else if (reset_any)  q_r <= 1'b0;
    else if (preset_any) q_r <= 1'b1;
    else if (clk_ev)     q_r <= q_nxt;
  end

  lcc_out_mux #(.NUM_OUT(NUM_OUT)) u_mux (
    .q    (q_r),
    .in_a (sum_a),
    .in_b (sum_b),
    .in_c (sum_c),
    .sel  (cfg_out_sel),
    .y    (data_out)
  );

  assign oe = sum_d & (csrc_e'(cfg_clk_src) != CSRC_SUMD);

endmodule

// File: rtl/lcc_cell_chk.sv
module lcc_cell_chk #(
  parameter int NUM_OUT = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 g_preset,
  input logic                 g_reset,
  input logic                 g_regtype,
  input logic                 sum_a,
  input logic                 sum_b,
  input logic                 sum_c,
  input logic                 sum_d,
  input logic [1:0]           cfg_kind,
  input logic [1:0]           cfg_clk_src,
  input logic                 cfg_b_preset,
  input logic                 cfg_c_reset,
  input logic [2*NUM_OUT-1:0] cfg_out_sel,
  input logic [NUM_OUT-1:0]   data_out,
  input logic                 oe,
  input logic                 q_r,
  input logic                 clk_ev
);

  logic rs_req;
  logic ps_req;
  assign rs_req = g_reset  || (cfg_c_reset  && sum_c);
  assign ps_req = g_preset || (cfg_b_preset && sum_b);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !q_r);

  a_r8_reset_wins: assert property (@(posedge clk) disable iff (rst)
    rs_req |=> !q_r);

  a_r8_preset_sets: assert property (@(posedge clk) disable iff (rst)
    (!rs_req && ps_req) |=> q_r);

  a_r6_hold_without_event: assert property (@(posedge clk) disable iff (rst)
    (!clk_ev && !rs_req && !ps_req) |=> $stable(q_r));

  a_r2_d_capture: assert property (@(posedge clk) disable iff (rst)
    (clk_ev && !rs_req && !ps_req && !g_regtype && (cfg_kind == 2'd0))
      |=> (q_r == $past(sum_a)));

  a_r10_oe_off_when_clock: assert property (@(posedge clk) disable iff (rst)
    (cfg_clk_src == 2'd2) |-> !oe);

  a_r9_out0_shows_q: assert property (@(posedge clk) disable iff (rst)
    (cfg_out_sel[1:0] == 2'd0) |-> (data_out[0] == q_r));

endmodule

bind lcc_cell lcc_cell_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .g_preset     (g_preset),
  .g_reset      (g_reset),
  .g_regtype    (g_regtype),
  .sum_a        (sum_a),
  .sum_b        (sum_b),
  .sum_c        (sum_c),
  .sum_d        (sum_d),
  .cfg_kind     (cfg_kind),
  .cfg_clk_src  (cfg_clk_src),
  .cfg_b_preset (cfg_b_preset),
  .cfg_c_reset  (cfg_c_reset),
  .cfg_out_sel  (cfg_out_sel),
  .data_out     (data_out),
  .oe           (oe),
  .q_r          (q_r),
  .clk_ev       (clk_ev)
);

// File: tb/tb_lcc_cell.sv
`timescale 1ns/1ps
module tb_lcc_cell;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       g_clk = 0, g_clk_neg = 0, g_preset = 0, g_reset = 0, g_regtype = 0;
  logic       sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0;
  logic [1:0] cfg_kind = 0, cfg_clk_src = 0;
  logic       cfg_alt_jk = 0, cfg_clk_inv = 0, cfg_b_preset = 0, cfg_c_reset = 0;
  logic [3:0] cfg_out_sel = 4'b0000;
  logic [1:0] data_out;
  logic       oe;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  lcc_cell dut (
    .clk(clk), .rst(rst), .g_clk(g_clk), .g_clk_neg(g_clk_neg),
    .g_preset(g_preset), .g_reset(g_reset), .g_regtype(g_regtype),
    .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d),
    .cfg_kind(cfg_kind), .cfg_alt_jk(cfg_alt_jk), .cfg_clk_src(cfg_clk_src),
    .cfg_clk_inv(cfg_clk_inv), .cfg_b_preset(cfg_b_preset),
    .cfg_c_reset(cfg_c_reset), .cfg_out_sel(cfg_out_sel),
    .data_out(data_out), .oe(oe)
  );

  // Ten cells form a loadable counter: D to load, T to count.
  logic       cnt_clk = 0, cnt_mode = 0;
  logic [9:0] cnt_load = 0;
  logic [9:0] cnt_q;
  logic [10:0] carry;
  assign carry[0] = 1'b1;
  for (genvar gi = 0; gi < 10; gi++) begin : g_cnt
    logic [1:0] bit_out;
    logic       bit_oe;
    assign carry[gi+1] = carry[gi] & cnt_q[gi];
    assign cnt_q[gi] = bit_out[0];
    lcc_cell u_bit (
      .clk(clk), .rst(rst), .g_clk(cnt_clk), .g_clk_neg(1'b0),
      .g_preset(1'b0), .g_reset(1'b0), .g_regtype(cnt_mode),
      .sum_a(cnt_mode ? carry[gi] : cnt_load[gi]), .sum_b(1'b0),
      .sum_c(1'b0), .sum_d(1'b0),
      .cfg_kind(2'd0), .cfg_alt_jk(1'b0), .cfg_clk_src(2'd0),
      .cfg_clk_inv(1'b0), .cfg_b_preset(1'b0), .cfg_c_reset(1'b0),
      .cfg_out_sel(4'b0000), .data_out(bit_out), .oe(bit_oe)
    );
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference of the single cell, stepped on every fabric edge.
  bit m_q = 0, m_prev = 0;
  always @(posedge clk) begin : model
    bit lvl, ev;
    int k;
    if (cfg_clk_src == 2'd1)      lvl = sum_c;
    else if (cfg_clk_src == 2'd2) lvl = sum_d;
    else                          lvl = g_clk ^ g_clk_neg;
    lvl = lvl ^ cfg_clk_inv;
    ev = lvl && !m_prev;
    m_prev = lvl;
    k = (cfg_kind == 2'd3) ? 0 : int'(cfg_kind);
    if (k == 0 && g_regtype) k = cfg_alt_jk ? 2 : 1;
    if (rst) m_q = 0;
    else if (g_reset || (cfg_c_reset && sum_c)) m_q = 0;
    else if (g_preset || (cfg_b_preset && sum_b)) m_q = 1;
    else if (ev) begin
      if (k == 1) m_q = m_q ^ sum_a;
      else if (k == 2) begin
        if (sum_a && sum_b) m_q = !m_q;
        else if (sum_a) m_q = 1;
        else if (sum_b) m_q = 0;
      end else m_q = sum_a;
    end
  end

  function automatic bit pick(input logic [1:0] s);
    case (s)
      2'd1: return sum_a;
      2'd2: return sum_b;
      2'd3: return sum_c;
      default: return m_q;
    endcase
  endfunction

  always begin
    @(posedge clk); #5;
    check(cur_req, data_out[0], pick(cfg_out_sel[1:0]), "per-clock data_out[0]");
    check(cur_req, data_out[1], pick(cfg_out_sel[3:2]), "per-clock data_out[1]");
    check(cur_req, oe, (cfg_clk_src != 2'd2) && sum_d, "per-clock oe");
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reconf();
    @(negedge clk) rst = 1;
    cyc(2);
    rst = 0;
  endtask

  // which: 0 global clock, 1 sum C, 2 sum D, 3 counter clock
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: g_clk = 1; 1: sum_c = 1; 2: sum_d = 1; default: cnt_clk = 1;
    endcase
    @(negedge clk);
    case (which)
      0: g_clk = 0; 1: sum_c = 0; 2: sum_d = 0; default: cnt_clk = 0;
    endcase
    @(negedge clk);
  endtask

  int cnt_ref;

  initial begin
    cyc(3);
    check("R1", data_out[0], 0, "bit after reset");
    check("R1", cnt_q, 0, "counter after reset");
    @(negedge clk) rst = 0;

    cur_req = "R2";
    sum_a = 1; pulse(0); check("R2", data_out[0], 1, "D load 1");
    sum_a = 0; pulse(0); check("R2", data_out[0], 0, "D load 0");
    cur_req = "R6";
    sum_a = 1; cyc(3); check("R6", data_out[0], 0, "no event keeps bit");

    cur_req = "R3"; cfg_kind = 1; reconf();
    sum_a = 1; pulse(0); check("R3", data_out[0], 1, "T toggle up");
    pulse(0); check("R3", data_out[0], 0, "T toggle down");
    sum_a = 0; pulse(0); check("R3", data_out[0], 0, "T hold");

    cur_req = "R4"; cfg_kind = 2; reconf();
    sum_a = 1; sum_b = 0; pulse(0); check("R4", data_out[0], 1, "JK set");
    sum_a = 0; pulse(0); check("R4", data_out[0], 1, "JK hold");
    sum_a = 1; sum_b = 1; pulse(0); check("R4", data_out[0], 0, "JK toggle 1->0");
    pulse(0); check("R4", data_out[0], 1, "JK toggle 0->1");
    sum_a = 0; pulse(0); check("R4", data_out[0], 0, "JK clear");

    cur_req = "R5"; sum_b = 0; cfg_kind = 0; g_regtype = 1; reconf();
    sum_a = 1; pulse(0); check("R5", data_out[0], 1, "dynamic T toggle");
    pulse(0); check("R5", data_out[0], 0, "dynamic T toggle back");
    cfg_alt_jk = 1; sum_b = 0; pulse(0); check("R5", data_out[0], 1, "dynamic JK set");
    sum_b = 1; pulse(0); check("R5", data_out[0], 0, "dynamic JK toggle");
    g_regtype = 0; sum_b = 0; pulse(0); check("R5", data_out[0], 1, "back to D");
    pulse(0); check("R5", data_out[0], 1, "D does not toggle");
    cfg_alt_jk = 0;

    cur_req = "R6"; cfg_clk_src = 1; reconf();
    sum_a = 1; pulse(0); check("R6", data_out[0], 0, "global ignored with C clock");
    pulse(1); check("R6", data_out[0], 1, "C clocks the bit");
    cfg_clk_src = 2; reconf();
    pulse(1); check("R6", data_out[0], 0, "C ignored with D clock");
    pulse(2); check("R6", data_out[0], 1, "D clocks the bit");
    @(negedge clk) sum_d = 1; @(negedge clk);
    check("R10", oe, 0, "oe low while D is clock");
    sum_d = 0;

    cur_req = "R7"; cfg_clk_src = 0; cfg_clk_inv = 1; reconf();
    sum_a = 1; @(negedge clk) g_clk = 1; cyc(2);
    check("R7", data_out[0], 0, "cell inverted: rise ignored");
    g_clk = 0; cyc(1); check("R7", data_out[0], 1, "cell inverted: fall clocks");
    cfg_clk_inv = 0; g_clk_neg = 1; reconf();
    @(negedge clk) g_clk = 1; cyc(2);
    check("R7", data_out[0], 0, "global inverted: rise ignored");
    g_clk = 0; cyc(1); check("R7", data_out[0], 1, "global inverted: fall clocks");
    cfg_clk_inv = 1; reconf();
    pulse(0); check("R7", data_out[0], 1, "double inversion: rise clocks");
    cfg_clk_inv = 0; g_clk_neg = 0; reconf();

    cur_req = "R8"; sum_a = 0;
    @(negedge clk) g_preset = 1; @(negedge clk) g_preset = 0;
    check("R8", data_out[0], 1, "global preset");
    g_reset = 1; g_preset = 1; @(negedge clk); g_reset = 0; g_preset = 0;
    check("R8", data_out[0], 0, "reset beats preset");
    cfg_b_preset = 1; sum_b = 1; @(negedge clk) sum_b = 0;
    check("R8", data_out[0], 1, "local preset by B");
    cfg_c_reset = 1; sum_c = 1; @(negedge clk) sum_c = 0;
    check("R8", data_out[0], 0, "local reset by C");
    cfg_b_preset = 0; cfg_c_reset = 0; sum_a = 1; g_reset = 1; pulse(0);
    check("R8", data_out[0], 0, "reset beats clock event");
    g_reset = 0;

    cur_req = "R9"; cfg_out_sel = 4'b11_01; sum_a = 1; sum_c = 0; @(negedge clk);
    check("R9", data_out[0], 1, "out0 shows A");
    check("R9", data_out[1], 0, "out1 shows C");
    sum_a = 0; sum_c = 1; #1;
    check("R9", data_out[0], 0, "out0 follows A");
    check("R9", data_out[1], 1, "out1 follows C");
    cfg_out_sel = 4'b00_10; sum_c = 0; sum_b = 1; @(negedge clk);
    check("R9", data_out[0], 1, "out0 shows B");
    check("R9", data_out[1], 0, "out1 shows Q");
    sum_b = 0; cfg_out_sel = 4'b0000;

    cur_req = "R10"; sum_d = 1; @(negedge clk);
    check("R10", oe, 1, "oe follows D");
    sum_d = 0; #1; check("R10", oe, 0, "oe follows D low");

    // R5: loadable counter, load in D, count in dynamic T
    cnt_mode = 0; cnt_load = 10'd1020; pulse(3); cnt_ref = 1020;
    check("R5", cnt_q, cnt_ref, "counter load");
    cnt_mode = 1;
    for (int s = 0; s < 5; s++) begin
      pulse(3); cnt_ref = (cnt_ref + 1) % 1024;
      check("R5", cnt_q, cnt_ref, "counter step");
    end
    cnt_mode = 0; cnt_load = 10'd5; pulse(3); cnt_ref = 5;
    check("R5", cnt_q, cnt_ref, "counter reload");
    cnt_mode = 1; pulse(3); cnt_ref = 6;
    check("R5", cnt_q, cnt_ref, "counter after reload");

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule